// File: doc/BRIEF.md
# Integer ALU Execute Stage with Offset-Selected Variants

This block is the integer execute stage of a 64-bit register machine. Each issued operation carries a 4-bit operation code, a 16-bit offset field, a width-class bit choosing 32-bit or 64-bit arithmetic, the current destination value and a source operand. The source operand is either a register value or a 32-bit immediate. One clock edge later the stage returns the value to write back to the destination, a write enable, and an illegal flag.

The offset field picks variants that share an operation code. Under the divide and modulo codes it chooses between the unsigned and the signed form. Under the move code it chooses a plain copy or a sign-extending copy from 8, 16 or 32 bits. Division never traps. A zero divisor gives a fixed, defined result. Any offset that is not defined for the decoded operation, and any unused operation code, marks the operation illegal and suppresses the write.

Top module: `alx_exec`

## Requirements
- R1: The operation code is applied with a latency of one cycle (`res_valid` follows `in_valid`). The codes are 0x0 add, 0x1 subtract, 0x2 multiply, 0x4 or, 0x5 and, 0x8 negate (destination only), 0xA xor and 0xB move (offset 0). Each of these needs offset 0 and wraps modulo 2^64 or 2^32 without any flag.
- R2: Code 0x3 with offset 0 is an unsigned divide, and a zero divisor yields 0. Code 0x9 with offset 0 is an unsigned remainder.
- R3: Code 0x3 with offset 1 is a signed divide that truncates toward zero. A zero divisor yields 0. The most negative value divided by -1 yields the most negative value.
- R4: Code 0x9 with offset 1 is a signed remainder that takes the sign of the dividend, and the most negative value modulo -1 yields 0. For either remainder form, a zero divisor returns the destination unchanged.
- R5: In 64-bit class, code 0xB with offset 8, 16 or 32 returns the low 8, 16 or 32 source bits sign-extended to 64 bits.
- R6: In 32-bit class, code 0xB with offset 8 or 16 sign-extends to 32 bits and clears bits 63:32. Offset 32 is illegal in this class.
- R7: Code 0x6 shifts left and code 0x7 shifts right logically. The shift amount is the source masked with 0x3F in 64-bit class and with 0x1F in 32-bit class.
- R8: Code 0xC shifts right arithmetically, replicating bit 63 in 64-bit class or bit 31 in 32-bit class, with the same masking as R7.
- R9: With `use_imm` set, the immediate is the source. In 64-bit class it is sign-extended from 32 bits. In 32-bit class only its 32 bits are used, so unsigned divide and remainder read it as unsigned.
- R10: Every 32-bit class result is computed on the low 32 bits of its operands and is zero-extended, so bits 63:32 of the result are 0.
- R11: Codes 0xD to 0xF are illegal, and so is any offset other than those listed in R1 to R6. An illegal operation raises `res_illegal`, keeps `res_write` low, and returns the destination value unchanged.
- R12: While `rst_n` is low at a clock edge, all outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (upper opcode nibble value) |
| op_offset | input | 16 | Offset field selecting the variant |
| is_wide | input | 1 | 1: 64-bit class, 0: 32-bit class |
| use_imm | input | 1 | 1: source is the immediate, 0: source register |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| imm_val | input | 32 | Immediate field |
| res_valid | output | 1 | Result of the previous cycle's operation is present |
| res_write | output | 1 | Destination should be written with `res_data` |
| res_illegal | output | 1 | The operation was illegal |
| res_data | output | 64 | Result value |

## Verification
On every cycle, the assertions check four things: the one-cycle valid latency, that an illegal operation never writes, that a 32-bit class write has zero upper bits, and the defined results of a zero register divisor for divide and remainder. Arithmetic values can only be shown by the bench's sweep. These values are the signed truncation, the most-negative-by-minus-one corner, shift masking, sign-extending moves and immediate extension. The sweep crosses every operation code with a range of offsets, both classes, both operand sources and boundary operand values, and compares each result with values computed in the bench.

// File: rtl/alx_pkg.sv
// Package: shared widths, operation codes and the decoded-control record for the
// integer execute stage. Assumes the operation code is the upper opcode nibble value.
package alx_pkg;
    localparam int OPC_W = 4;
    localparam int OFF_W = 16;

    typedef enum logic [OPC_W-1:0] {
        OPC_ADD  = 4'h0,
        OPC_SUB  = 4'h1,
        OPC_MUL  = 4'h2,
        OPC_DIV  = 4'h3,
        OPC_OR   = 4'h4,
        OPC_AND  = 4'h5,
        OPC_SHL  = 4'h6,
        OPC_SHR  = 4'h7,
        OPC_NEG  = 4'h8,
        OPC_MOD  = 4'h9,
        OPC_XOR  = 4'hA,
        OPC_MOV  = 4'hB,
        OPC_SAR  = 4'hC
    } alx_opc_e;

    // Width selector for sign-extending move
    typedef enum logic [1:0] {
        SX_NONE = 2'd0,
        SX_B8   = 2'd1,
        SX_B16  = 2'd2,
        SX_HALF = 2'd3
    } alx_sx_e;

    typedef struct packed {
        logic    legal;
        logic    signed_dm;
        alx_sx_e sx_sel;
    } alx_ctl_t;
endpackage

// File: rtl/alx_decode.sv
// Module: alx_decode
// Checks the offset field against the operation code and derives the variant
// controls. Assumes offset values are exact encodings (0, 1, 8, 16, 32).
module alx_decode
    import alx_pkg::*;
(
    input  logic [OPC_W-1:0] op_code,
    input  logic [OFF_W-1:0] op_offset,
    input  logic             is_wide,
    output alx_ctl_t         ctl
);
    localparam logic [OFF_W-1:0] OFF_ZERO = '0;
    localparam logic [OFF_W-1:0] OFF_ONE  = OFF_W'(1);
    localparam logic [OFF_W-1:0] OFF_8    = OFF_W'(8);
    localparam logic [OFF_W-1:0] OFF_16   = OFF_W'(16);
    localparam logic [OFF_W-1:0] OFF_32   = OFF_W'(32);

    // Legality and variant selection per operation code
    always_comb begin
        ctl = '{legal: 1'b0, signed_dm: 1'b0, sx_sel: SX_NONE};
        unique case (op_code)
            OPC_DIV, OPC_MOD: begin
                ctl.legal     = (op_offset == OFF_ZERO) || (op_offset == OFF_ONE);
                ctl.signed_dm = (op_offset == OFF_ONE);
            end
            OPC_MOV: begin
                if (op_offset == OFF_ZERO) begin
                    ctl.legal = 1'b1;
                end else if (op_offset == OFF_8) begin
                    ctl.legal  = 1'b1;
                    ctl.sx_sel = SX_B8;
                end else if (op_offset == OFF_16) begin
                    ctl.legal  = 1'b1;
                    ctl.sx_sel = SX_B16;
                end else if (op_offset == OFF_32 && is_wide) begin
                    ctl.legal  = 1'b1;
                    ctl.sx_sel = SX_HALF;
                end
            end
            OPC_ADD, OPC_SUB, OPC_MUL, OPC_OR, OPC_AND, OPC_SHL,
            OPC_SHR, OPC_NEG, OPC_XOR, OPC_SAR: begin
                ctl.legal = (op_offset == OFF_ZERO);
            end
            default: ctl.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/alx_operands.sv
// Module: alx_operands
// Picks the source (register or immediate) and presents both operands
// zero- and sign-extended from the active class width. Assumes IMM_W == DATA_W/2.
module alx_operands #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic              is_wide,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm_val,
    output logic [DATA_W-1:0] a_zx,
    output logic [DATA_W-1:0] a_sx,
    output logic [DATA_W-1:0] b_zx,
    output logic [DATA_W-1:0] b_sx
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] b_raw;

    // Source select; immediate is sign-extended in wide class, kept as-is otherwise
    always_comb begin
        if (!use_imm)
            b_raw = src_val;
        else if (is_wide)
            b_raw = {{(DATA_W-IMM_W){imm_val[IMM_W-1]}}, imm_val};
        else
            b_raw = {{(DATA_W-IMM_W){1'b0}}, imm_val};
    end

    // Class-width extension of both operands
    always_comb begin
        if (is_wide) begin
            a_zx = dst_val;
            a_sx = dst_val;
            b_zx = b_raw;
            b_sx = b_raw;
        end else begin
            a_zx = {{HALF_W{1'b0}}, dst_val[HALF_W-1:0]};
            a_sx = {{HALF_W{dst_val[HALF_W-1]}}, dst_val[HALF_W-1:0]};
            b_zx = {{HALF_W{1'b0}}, b_raw[HALF_W-1:0]};
            b_sx = {{HALF_W{b_raw[HALF_W-1]}}, b_raw[HALF_W-1:0]};
        end
    end
endmodule

// File: rtl/alx_divmod.sv
// Module: alx_divmod
// Sign-magnitude divider: quotient truncates toward zero, remainder takes the
// dividend's sign. Assumes operands already extended to DATA_W; zero-divisor
// outcome is chosen by the caller.
module alx_divmod #(
    parameter int DATA_W = 64
) (
    input  logic              signed_op,
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor,
    output logic              div_zero,
    output logic [DATA_W-1:0] quotient,
    output logic [DATA_W-1:0] remainder
);
    logic              neg_n, neg_d;
    logic [DATA_W-1:0] mag_n, mag_d, uq, ur;

    // Magnitudes of the operands for the signed form
    always_comb begin
        neg_n = signed_op & dividend[DATA_W-1];
        neg_d = signed_op & divisor[DATA_W-1];
        mag_n = neg_n ? (~dividend + 1'b1) : dividend;
        mag_d = neg_d ? (~divisor + 1'b1) : divisor;
        div_zero = (divisor == '0);
    end

    // Unsigned core division with zero guard
    always_comb begin
        if (div_zero) begin
            uq = '0;
            ur = '0;
        end else begin
            uq = mag_n / mag_d;
            ur = mag_n % mag_d;
        end
    end

    // Sign restoration
    always_comb begin
        quotient  = (neg_n ^ neg_d) ? (~uq + 1'b1) : uq;
        remainder = neg_n ? (~ur + 1'b1) : ur;
    end
endmodule

// File: rtl/alx_datapath.sv
// Module: alx_datapath
// Computes every legal operation on class-extended operands and narrows the
// 32-bit class result with zero extension. Assumes decode has validated offsets.
module alx_datapath
    import alx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [OPC_W-1:0]  op_code,
    input  alx_ctl_t          ctl,
    input  logic              is_wide,
    input  logic [DATA_W-1:0] a_zx,
    input  logic [DATA_W-1:0] a_sx,
    input  logic [DATA_W-1:0] b_zx,
    input  logic [DATA_W-1:0] b_sx,
    output logic [DATA_W-1:0] result
);
    localparam int HALF_W  = DATA_W / 2;
    localparam int SHAMT_W = $clog2(DATA_W);

    logic              dz;
    logic [DATA_W-1:0] quo, rem, full;
    logic [SHAMT_W-1:0] shamt;

    alx_divmod #(.DATA_W(DATA_W)) u_divmod (
        .signed_op (ctl.signed_dm),
        .dividend  (ctl.signed_dm ? a_sx : a_zx),
        .divisor   (ctl.signed_dm ? b_sx : b_zx),
        .div_zero  (dz),
        .quotient  (quo),
        .remainder (rem)
    );

    // Shift amount masked to the class width
    always_comb begin
        shamt = is_wide ? b_zx[SHAMT_W-1:0] : {1'b0, b_zx[SHAMT_W-2:0]};
    end

    // Operation mux at full width
    always_comb begin
        unique case (op_code)
            OPC_ADD: full = a_zx + b_zx;
            OPC_SUB: full = a_zx - b_zx;
            OPC_MUL: full = a_zx * b_zx;
            OPC_DIV: full = dz ? '0 : quo;
            OPC_OR:  full = a_zx | b_zx;
            OPC_AND: full = a_zx & b_zx;
            OPC_SHL: full = a_zx << shamt;
            OPC_SHR: full = a_zx >> shamt;
            OPC_NEG: full = ~a_zx + 1'b1;
            OPC_MOD: full = dz ? a_zx : rem;
            OPC_XOR: full = a_zx ^ b_zx;
            OPC_MOV: begin
                unique case (ctl.sx_sel)
                    SX_B8:   full = {{(DATA_W-8){b_zx[7]}}, b_zx[7:0]};
                    SX_B16:  full = {{(DATA_W-16){b_zx[15]}}, b_zx[15:0]};
                    SX_HALF: full = {{HALF_W{b_zx[HALF_W-1]}}, b_zx[HALF_W-1:0]};
                    default: full = b_zx;
                endcase
            end
            OPC_SAR: full = $unsigned($signed(a_sx) >>> shamt);
            default: full = a_zx;
        endcase
    end

    // Narrow-class results are zero-extended
    always_comb begin
        result = is_wide ? full : {{HALF_W{1'b0}}, full[HALF_W-1:0]};
    end
endmodule

// File: rtl/alx_exec.sv
// Module: alx_exec (top)
// One-cycle integer execute stage: decodes the offset-qualified variant,
// computes the result and registers it with write enable and illegal flag.
// Assumes the register file and fetch live outside this block.
module alx_exec
    import alx_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op_code,
    input  logic [15:0]       op_offset,
    input  logic              is_wide,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm_val,
    output logic              res_valid,
    output logic              res_write,
    output logic              res_illegal,
    output logic [DATA_W-1:0] res_data
);
    localparam int HALF_W = DATA_W / 2;

    alx_ctl_t          ctl;
    logic [DATA_W-1:0] a_zx, a_sx, b_zx, b_sx, alu_res;

    alx_decode u_decode (
        .op_code   (op_code),
        .op_offset (op_offset),
        .is_wide   (is_wide),
        .ctl       (ctl)
    );

    alx_operands #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_operands (
        .is_wide (is_wide),
        .use_imm (use_imm),
        .dst_val (dst_val),
        .src_val (src_val),
        .imm_val (imm_val),
        .a_zx    (a_zx),
        .a_sx    (a_sx),
        .b_zx    (b_zx),
        .b_sx    (b_sx)
    );

    alx_datapath #(.DATA_W(DATA_W)) u_datapath (
        .op_code (op_code),
        .ctl     (ctl),
        .is_wide (is_wide),
        .a_zx    (a_zx),
        .a_sx    (a_sx),
        .b_zx    (b_zx),
        .b_sx    (b_sx),
        .result  (alu_res)
    );

    // Output register: result, write enable and illegal flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_write   <= 1'b0;
            res_illegal <= 1'b0;
            res_data    <= '0;
        end else begin
            res_valid   <= in_valid;
            res_write   <= in_valid & ctl.legal;
            res_illegal <= in_valid & ~ctl.legal;
            if (in_valid)
                res_data <= ctl.legal ? alu_res : dst_val;
        end
    end

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    // R11
    illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_illegal |-> (!res_write && res_valid));

    // R10
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_wide) |=> (!res_write || res_data[DATA_W-1:HALF_W] == '0));

    // R2
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 4'h3 && op_offset == 16'd0 && !use_imm && src_val == '0)
        |=> (res_write && res_data == '0));

    // R4
    mod_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_wide && op_code == 4'h9 && op_offset <= 16'd1 && !use_imm && src_val == '0)
        |=> (res_write && res_data == $past(dst_val)));
endmodule

// File: tb/alx_exec_tb.sv
module alx_exec_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [15:0] op_offset = '0;
    logic        is_wide = 1'b0;
    logic        use_imm = 1'b0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] imm_val = '0;
    logic        res_valid, res_write, res_illegal;
    logic [63:0] res_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alx_exec u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .op_offset(op_offset), .is_wide(is_wide), .use_imm(use_imm),
        .dst_val(dst_val), .src_val(src_val), .imm_val(imm_val),
        .res_valid(res_valid), .res_write(res_write), .res_illegal(res_illegal),
        .res_data(res_data)
    );

    localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;
    localparam logic [31:0] MIN32 = 32'h8000_0000;

    // Reference computed from the requirement text
    function automatic void model(input logic [3:0] op, input logic [15:0] off,
                                  input bit wide, input bit ui, input logic [63:0] d,
                                  input logic [63:0] s, input logic [31:0] im,
                                  output bit ill, output logic [63:0] r);
        logic [63:0] b;
        logic [31:0] x, y, t;
        b = ui ? (wide ? {{32{im[31]}}, im} : {32'h0, im}) : s;
        case (op)
            4'h3, 4'h9: ill = (off > 16'd1);
            4'hB: ill = !(off == 0 || off == 8 || off == 16 || (off == 32 && wide));
            4'hD, 4'hE, 4'hF: ill = 1'b1;
            default: ill = (off != 0);
        endcase
        r = d;
        if (ill) return;
        if (wide) begin
            case (op)
                4'h0: r = d + b;
                4'h1: r = d - b;
                4'h2: r = d * b;
                4'h3: if (b == 0) r = 0;
                      else if (off == 0) r = d / b;
                      else if (d == MIN64 && b == '1) r = MIN64;
                      else r = $signed(d) / $signed(b);
                4'h4: r = d | b;
                4'h5: r = d & b;
                4'h6: r = d << b[5:0];
                4'h7: r = d >> b[5:0];
                4'h8: r = 64'd0 - d;
                4'h9: if (b == 0) r = d;
                      else if (off == 0) r = d % b;
                      else if (d == MIN64 && b == '1) r = 0;
                      else r = $signed(d) % $signed(b);
                4'hA: r = d ^ b;
                4'hB: r = (off == 8) ? {{56{b[7]}}, b[7:0]} :
                          (off == 16) ? {{48{b[15]}}, b[15:0]} :
                          (off == 32) ? {{32{b[31]}}, b[31:0]} : b;
                default: r = $signed(d) >>> b[5:0];
            endcase
        end else begin
            x = d[31:0];
            y = b[31:0];
            case (op)
                4'h0: t = x + y;
                4'h1: t = x - y;
                4'h2: t = x * y;
                4'h3: if (y == 0) t = 0;
                      else if (off == 0) t = x / y;
                      else if (x == MIN32 && y == '1) t = MIN32;
                      else t = $signed(x) / $signed(y);
                4'h4: t = x | y;
                4'h5: t = x & y;
                4'h6: t = x << y[4:0];
                4'h7: t = x >> y[4:0];
                4'h8: t = 32'd0 - x;
                4'h9: if (y == 0) t = x;
                      else if (off == 0) t = x % y;
                      else if (x == MIN32 && y == '1) t = 0;
                      else t = $signed(x) % $signed(y);
                4'hA: t = x ^ y;
                4'hB: t = (off == 8) ? {{24{y[7]}}, y[7:0]} :
                          (off == 16) ? {{16{y[15]}}, y[15:0]} : y;
                default: t = $signed(x) >>> y[4:0];
            endcase
            r = {32'h0, t};
        end
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic [15:0] off,
                                     input bit wide, input bit ill);
        if (ill) return "R11";
        case (op)
            4'h3: return (off == 1) ? "R3" : "R2";
            4'h9: return "R4";
            4'hB: return (off == 0) ? (wide ? "R1" : "R10") : (wide ? "R5" : "R6");
            4'h6, 4'h7: return "R7";
            4'hC: return "R8";
            default: return wide ? "R1" : "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge (one register)
    task automatic run_op(input logic [3:0] op, input logic [15:0] off, input bit wide,
                          input bit ui, input logic [63:0] d, input logic [63:0] s,
                          input logic [31:0] im, input string tag_force);
        bit ill;
        logic [63:0] r;
        string tg;
        @(negedge clk);
        in_valid = 1'b1; op_code = op; op_offset = off; is_wide = wide;
        use_imm = ui; dst_val = d; src_val = s; imm_val = im;
        model(op, off, wide, ui, d, s, im, ill, r);
        tg = (tag_force != "") ? tag_force : tag_of(op, off, wide, ill);
        @(negedge clk);
        check(tg, {63'd0, res_valid}, 64'd1);
        check(tg, {63'd0, res_illegal}, {63'd0, ill});
        check(tg, {63'd0, res_write}, {63'd0, !ill});
        check(tg, res_data, r);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] vals [8];
        logic [15:0] offs [7];
        vals[0] = 64'h0;                    vals[1] = 64'h1;
        vals[2] = 64'hFFFF_FFFF_FFFF_FFFF;  vals[3] = MIN64;
        vals[4] = 64'h0000_0000_8000_0000;  vals[5] = 64'h1234_5678_9ABC_DEF0;
        vals[6] = 64'h0000_0000_0000_0025;  vals[7] = 64'hFFFF_FFFF_FFFF_FF85;
        offs[0] = 16'd0; offs[1] = 16'd1; offs[2] = 16'd2; offs[3] = 16'd8;
        offs[4] = 16'd16; offs[5] = 16'd32; offs[6] = 16'hFFFF;

        // R12: reset clears outputs
        in_valid = 1'b1; op_code = 4'h0; dst_val = 64'h55; src_val = 64'h1;
        repeat (3) @(negedge clk);
        check("R12", {61'd0, res_valid, res_write, res_illegal}, 64'd0);
        check("R12", res_data, 64'd0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // Directed corners
        run_op(4'h0, 16'd0, 1'b1, 1'b1, 64'd0, 64'd0, 32'hFFFF_FFFF, "R9");
        run_op(4'h0, 16'd0, 1'b0, 1'b1, 64'd0, 64'd0, 32'hFFFF_FFFF, "R9");
        run_op(4'h3, 16'd0, 1'b0, 1'b1, 64'hFFFF_FFFF, 64'd0, 32'hFFFF_FFFE, "R9");
        run_op(4'h3, 16'd1, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFF9, 64'd2, 32'd0, "R3");
        run_op(4'h9, 16'd1, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFF9, 64'd2, 32'd0, "R4");
        run_op(4'hB, 16'd32, 1'b0, 1'b0, 64'd7, 64'h8000_0000, 32'd0, "R6");
        run_op(4'hB, 16'd32, 1'b1, 1'b0, 64'd7, 64'h8000_0000, 32'd0, "R5");
        run_op(4'hD, 16'd0, 1'b1, 1'b0, 64'hABCD, 64'd1, 32'd0, "R11");

        // Near-exhaustive sweep over codes, offsets, classes, sources, operands
        for (int op = 0; op < 16; op++)
            for (int oi = 0; oi < 7; oi++)
                for (int w = 0; w < 2; w++)
                    for (int ui = 0; ui < 2; ui++)
                        for (int di = 0; di < 8; di++)
                            for (int si = 0; si < 8; si++)
                                run_op(4'(op), offs[oi], w[0], ui[0], vals[di],
                                       vals[si], vals[si][31:0], "");

        // R1: valid drops one cycle after in_valid drops
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R1", {63'd0, res_valid}, 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule